// File: doc/BRIEF.md
# TDM Serial Audio Transmit Framer

This block serialises audio sample words onto up to six data pins of a multi-slot time-division serial link and generates the frame sync that marks each frame. The parent logic supplies a one-cycle bit-clock enable for every bit period, a set of parallel sample words (one lane per data pin) with a valid flag, and a quasi-static configuration. On each bit period the block shifts one bit per active pin, MSB first. It pops one set of lane words at the start of every slot that carries data.

Timing variants such as I2S, left-justified, right-justified and the two DSP styles are built from four frame-sync controls: length (whole slot or one bit), early placement (one bit before the first data bit), polarity, and word alignment within the slot. A 32-bit slot mask, supplied as two 16-bit halves, suppresses individual slots. A mode switch selects between sending one word per frame (single channel) and one word per slot (network). When a data slot starts and no words are available, the block sends zeros and raises an underrun flag for that bit period. A separate flag marks the first bit of the last slot in every frame.

Configuration is sampled live and must be held steady while `tx_en` is high.

Top module: `tdm_tx_framer`

## Requirements
- R1: While `tx_en` is low, and after reset, every data pin is 0, `fs_o` sits at its inactive level (`cfg_fs_inv`), `last_slot_o` and `underrun_o` are 0, and `fifo_pop` is never asserted.
- R2: After `tx_en` rises, the first `bclk_en` starts one lead-in bit period with no data. Each later `bclk_en` moves to the next bit. A frame is `cfg_slots` (1..32) slots of `cfg_slot_w` (2..32) bits each. Data goes out MSB first, and outputs change only on the clock edge that samples `bclk_en` high.
- R3: With `cfg_fs_word`=1, frame sync is active for every bit of slot 0. With `cfg_fs_word`=0, it is active only for bit 0 of slot 0.
- R4: With `cfg_fs_early`=1, the whole frame-sync pattern moves one bit period earlier. For the first frame, this means the lead-in bit.
- R5: `cfg_fs_inv`=1 makes `fs_o` active low. With `cfg_fs_inv`=0 it is active high.
- R6: The sample is the low `cfg_width` bits of its lane word. With `cfg_right_just`=0 it fills the first `cfg_width` bits of the slot. With `cfg_right_just`=1 it fills the last `cfg_width` bits. All other slot bits are 0.
- R7: Slot i carries data only when mask bit i is set. Bit i of `cfg_mask_lo` covers slots 0-15, and bit i of `cfg_mask_hi` covers slot 16+i. A masked slot sends zeros and pops nothing.
- R8: With `cfg_network`=1, every unmasked slot carries a word. With `cfg_network`=0, only slot 0 does (if mask bit 0 is set), so one word is sent per frame.
- R9: The number of active pins is ceil(`cfg_chans`/`cfg_slots`), capped at 6. Pin p sends lane p (bits [32p+31:32p] of `fifo_data`). Pins at or above the active count stay 0.
- R10: If `fifo_valid` is low when a data slot begins, that slot sends zeros on all pins, nothing is popped, and `underrun_o` is high for that one bit period.
- R11: `last_slot_o` is high for exactly the bit period holding bit 0 of slot `cfg_slots`-1.
- R12: `fifo_pop` is a one-cycle pulse in the `bclk_en` cycle that begins a data slot while `fifo_valid` is high. The number of pops equals the number of such slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Enables framing; low forces idle |
| bclk_en | input | 1 | One-cycle pulse per bit period |
| cfg_slots | input | 6 | Slots per frame, 1..32 |
| cfg_slot_w | input | 6 | Bits per slot, 2..32 |
| cfg_width | input | 6 | Sample bits, 1..cfg_slot_w |
| cfg_chans | input | 8 | Channel count used for pin count |
| cfg_network | input | 1 | 1 = word per slot, 0 = word per frame |
| cfg_fs_word | input | 1 | 1 = sync lasts slot 0, 0 = one bit |
| cfg_fs_early | input | 1 | Sync one bit before frame data |
| cfg_fs_inv | input | 1 | 1 = active-low sync |
| cfg_right_just | input | 1 | Sample placed at end of slot |
| cfg_mask_lo | input | 16 | Enables for slots 0-15 |
| cfg_mask_hi | input | 16 | Enables for slots 16-31 |
| fifo_valid | input | 1 | A full set of lane words is available |
| fifo_data | input | 192 | Six 32-bit lane words |
| fifo_pop | output | 1 | Consume the current lane words |
| fs_o | output | 1 | Frame sync |
| sdata_o | output | 6 | Serial data pins |
| last_slot_o | output | 1 | First bit of the final slot |
| underrun_o | output | 1 | Data slot began without words |

## Verification
The assertions check, on every cycle, the properties that are local in time. Outputs hold between bit-clock enables, the block stays quiet while disabled, pops are qualified and single-cycle, underruns follow an empty start, pins above the active count stay zero, and the single-bit sync and last-slot flag never last beyond one bit period. Only the bench scenarios can show the stream content. That covers where the sync falls in each timing variant, how samples are aligned and padded, which slots the mask and the mode suppress, which word lands on which pin, and how many words a frame consumes. The bench checks these against a bit-by-bit expectation it derives from the frame position.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_e;

  // Position the sample inside a max_w-bit shift word whose MSB goes out first.
  function automatic logic [31:0] slot_fmt(input logic [31:0] smp,
                                           input logic [31:0] width,
                                           input logic [31:0] slot_w,
                                           input logic        right,
                                           input logic [31:0] max_w);
    logic [31:0] keep;
    logic [31:0] sh;
    keep = (width >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF << width);
    sh   = right ? (max_w - slot_w) : (max_w - width);
    return (smp & keep) << sh;
  endfunction

  // Data pins needed to carry chans channels over slots slots, capped.
  function automatic logic [31:0] pin_count(input logic [31:0] chans,
                                            input logic [31:0] slots,
                                            input logic [31:0] max_pins);
    logic [31:0] n;
    if (slots == 0) return 32'd0;
    n = (chans + slots - 1) / slots;
    return (n > max_pins) ? max_pins : n;
  endfunction

  // Frame sync pattern at a frame position, before any shift or inversion.
  function automatic logic fs_hit(input logic [31:0] slot,
                                  input logic [31:0] bitpos,
                                  input logic        word);
    return (slot == 0) && (word || (bitpos == 0));
  endfunction

endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing
  import tdm_tx_pkg::*;
#(
  parameter int MAX_W     = 32,
  parameter int MAX_SLOTS = 32,
  localparam int BW  = $clog2(MAX_W),
  localparam int SW  = $clog2(MAX_SLOTS),
  localparam int CWW = $clog2(MAX_W + 1),
  localparam int CSW = $clog2(MAX_SLOTS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_en,
  input  logic           bclk_en,
  input  logic [CSW-1:0] cfg_slots,
  input  logic [CWW-1:0] cfg_slot_w,
  input  logic           cfg_fs_word,
  input  logic           cfg_fs_early,
  output logic           step_o,
  output logic           slot_start_o,
  output logic [SW-1:0]  nx_slot_o,
  output logic           fs_act_o,
  output logic           last_slot_o
);

  tx_state_e      st_q;
  logic [BW-1:0]  bit_q;
  logic [SW-1:0]  slot_q;
  logic [BW-1:0]  last_bit;
  logic [SW-1:0]  last_slot_idx;
  logic [BW-1:0]  np_bit, nn_bit;
  logic [SW-1:0]  np_slot, nn_slot;
  logic           fs_next;
  logic           fs_q;
  logic           ls_q;

  assign last_bit      = BW'(cfg_slot_w - CWW'(1));
  assign last_slot_idx = SW'(cfg_slots - CSW'(1));

  function automatic logic [SW+BW-1:0] advance(input logic [SW-1:0] s,
                                               input logic [BW-1:0] b,
                                               input logic [SW-1:0] ls,
                                               input logic [BW-1:0] lb);
    if (b != lb) return {s, b + BW'(1)};
    if (s == ls) return '0;
    return {s + SW'(1), BW'(0)};
  endfunction

  always_comb begin
    unique case (st_q)
      ST_IDLE: {np_slot, np_bit} = {last_slot_idx, last_bit};
      ST_LEAD: {np_slot, np_bit} = '0;
      default: {np_slot, np_bit} = advance(slot_q, bit_q, last_slot_idx, last_bit);
    endcase
    {nn_slot, nn_bit} = advance(np_slot, np_bit, last_slot_idx, last_bit);
    if (cfg_fs_early)
      fs_next = fs_hit(32'(nn_slot), 32'(nn_bit), cfg_fs_word);
    else
      fs_next = (st_q != ST_IDLE) && fs_hit(32'(np_slot), 32'(np_bit), cfg_fs_word);
  end

  assign step_o       = bclk_en && tx_en && (st_q != ST_IDLE);
  assign slot_start_o = step_o && (np_bit == '0);
  assign nx_slot_o    = np_slot;
  assign fs_act_o     = fs_q;
  assign last_slot_o  = ls_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      slot_q <= '0;
      fs_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else if (bclk_en) begin
      st_q <= (st_q == ST_IDLE) ? ST_LEAD : ST_RUN;
      if (st_q != ST_IDLE) begin
        slot_q <= np_slot;
        bit_q  <= np_bit;
      end
      fs_q <= fs_next;
      ls_q <= (st_q != ST_IDLE) && (np_bit == '0) && (np_slot == last_slot_idx);
    end
  end

endmodule

// File: rtl/tdm_tx_slot_sel.sv
module tdm_tx_slot_sel
  import tdm_tx_pkg::*;
#(
  parameter int NPINS     = 6,
  parameter int MAX_SLOTS = 32,
  localparam int SW   = $clog2(MAX_SLOTS),
  localparam int CSW  = $clog2(MAX_SLOTS + 1),
  localparam int CHW  = $clog2(NPINS * MAX_SLOTS + 1),
  localparam int PW   = $clog2(NPINS + 1),
  localparam int HALF = MAX_SLOTS / 2
) (
  input  logic            cfg_network,
  input  logic [HALF-1:0] cfg_mask_lo,
  input  logic [HALF-1:0] cfg_mask_hi,
  input  logic [CHW-1:0]  cfg_chans,
  input  logic [CSW-1:0]  cfg_slots,
  input  logic [SW-1:0]   cur_slot,
  output logic            slot_tx_o,
  output logic [PW-1:0]   active_pins_o
);

  logic [MAX_SLOTS-1:0] mask_full;

  assign mask_full = {cfg_mask_hi, cfg_mask_lo};

  always_comb begin
    if (cfg_network) slot_tx_o = mask_full[cur_slot];
    else             slot_tx_o = (cur_slot == '0) && mask_full[0];
  end

  assign active_pins_o = PW'(pin_count(32'(cfg_chans), 32'(cfg_slots), 32'(NPINS)));

endmodule

// File: rtl/tdm_tx_lanes.sv
module tdm_tx_lanes
  import tdm_tx_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int MAX_W = 32,
  localparam int CWW = $clog2(MAX_W + 1),
  localparam int PW  = $clog2(NPINS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_en,
  input  logic                   step,
  input  logic                   slot_start,
  input  logic                   load_en,
  input  logic [NPINS*MAX_W-1:0] fifo_data,
  input  logic [CWW-1:0]         cfg_width,
  input  logic [CWW-1:0]         cfg_slot_w,
  input  logic                   cfg_right_just,
  input  logic [PW-1:0]          active_pins,
  output logic [NPINS-1:0]       sdata_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_lane
    logic [MAX_W-1:0] sh_q;
    logic [MAX_W-1:0] fmt_word;
    logic             lane_on;

    assign lane_on  = load_en && (PW'(p) < active_pins);
    assign fmt_word = MAX_W'(slot_fmt(32'(fifo_data[p*MAX_W +: MAX_W]),
                                      32'(cfg_width), 32'(cfg_slot_w),
                                      cfg_right_just, 32'(MAX_W)));

    always_ff @(posedge clk) begin
      if (!rst_n || !tx_en)  sh_q <= '0;
      else if (slot_start)   sh_q <= lane_on ? fmt_word : '0;
      else if (step)         sh_q <= sh_q << 1;
    end

    assign sdata_o[p] = sh_q[MAX_W-1];
  end

endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
#(
  parameter int NPINS     = 6,
  parameter int MAX_W     = 32,
  parameter int MAX_SLOTS = 32,
  localparam int SW   = $clog2(MAX_SLOTS),
  localparam int CWW  = $clog2(MAX_W + 1),
  localparam int CSW  = $clog2(MAX_SLOTS + 1),
  localparam int CHW  = $clog2(NPINS * MAX_SLOTS + 1),
  localparam int PW   = $clog2(NPINS + 1),
  localparam int HALF = MAX_SLOTS / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_en,
  input  logic                   bclk_en,
  input  logic [CSW-1:0]         cfg_slots,
  input  logic [CWW-1:0]         cfg_slot_w,
  input  logic [CWW-1:0]         cfg_width,
  input  logic [CHW-1:0]         cfg_chans,
  input  logic                   cfg_network,
  input  logic                   cfg_fs_word,
  input  logic                   cfg_fs_early,
  input  logic                   cfg_fs_inv,
  input  logic                   cfg_right_just,
  input  logic [HALF-1:0]        cfg_mask_lo,
  input  logic [HALF-1:0]        cfg_mask_hi,
  input  logic                   fifo_valid,
  input  logic [NPINS*MAX_W-1:0] fifo_data,
  output logic                   fifo_pop,
  output logic                   fs_o,
  output logic [NPINS-1:0]       sdata_o,
  output logic                   last_slot_o,
  output logic                   underrun_o
);

  logic          step;
  logic          slot_start;
  logic [SW-1:0] nx_slot;
  logic          fs_act;
  logic          slot_tx;
  logic [PW-1:0] active_pins;
  logic          underrun_q;

  tdm_tx_timing #(.MAX_W(MAX_W), .MAX_SLOTS(MAX_SLOTS)) u_timing (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .bclk_en      (bclk_en),
    .cfg_slots    (cfg_slots),
    .cfg_slot_w   (cfg_slot_w),
    .cfg_fs_word  (cfg_fs_word),
    .cfg_fs_early (cfg_fs_early),
    .step_o       (step),
    .slot_start_o (slot_start),
    .nx_slot_o    (nx_slot),
    .fs_act_o     (fs_act),
    .last_slot_o  (last_slot_o)
  );

  tdm_tx_slot_sel #(.NPINS(NPINS), .MAX_SLOTS(MAX_SLOTS)) u_sel (
    .cfg_network   (cfg_network),
    .cfg_mask_lo   (cfg_mask_lo),
    .cfg_mask_hi   (cfg_mask_hi),
    .cfg_chans     (cfg_chans),
    .cfg_slots     (cfg_slots),
    .cur_slot      (nx_slot),
    .slot_tx_o     (slot_tx),
    .active_pins_o (active_pins)
  );

  assign fifo_pop = slot_start && slot_tx && fifo_valid;

  tdm_tx_lanes #(.NPINS(NPINS), .MAX_W(MAX_W)) u_lanes (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_en          (tx_en),
    .step           (step),
    .slot_start     (slot_start),
    .load_en        (fifo_pop),
    .fifo_data      (fifo_data),
    .cfg_width      (cfg_width),
    .cfg_slot_w     (cfg_slot_w),
    .cfg_right_just (cfg_right_just),
    .active_pins    (active_pins),
    .sdata_o        (sdata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) underrun_q <= 1'b0;
    else if (bclk_en)     underrun_q <= slot_start && slot_tx && !fifo_valid;
  end

  assign underrun_o = underrun_q;
  assign fs_o       = fs_act ^ cfg_fs_inv;

endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker #(
  parameter int NPINS = 6,
  localparam int PW = $clog2(NPINS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             bclk_en,
  input logic             fifo_valid,
  input logic             fifo_pop,
  input logic             fs_act,
  input logic             slot_start,
  input logic             slot_tx,
  input logic             cfg_fs_word,
  input logic [PW-1:0]    active_pins,
  input logic [NPINS-1:0] sdata_o,
  input logic             last_slot_o,
  input logic             underrun_o
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (sdata_o == '0) && !fs_act && !last_slot_o && !underrun_o);

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !bclk_en) |=> $stable(sdata_o) && $stable(fs_act) && $stable(last_slot_o));

  p_fs_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && bclk_en && fs_act && !cfg_fs_word) |=> !fs_act);

  p_unused_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> ((sdata_o >> active_pins) == '0));

  p_underrun_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && slot_start && slot_tx && !fifo_valid) |=> underrun_o);

  p_no_pop_with_underrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !underrun_o);

  p_last_slot_one_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && bclk_en && last_slot_o) |=> !last_slot_o);

  p_pop_qualified_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_valid && bclk_en && tx_en));

  p_pop_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

endmodule

bind tdm_tx_framer tdm_tx_checker #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .bclk_en     (bclk_en),
  .fifo_valid  (fifo_valid),
  .fifo_pop    (fifo_pop),
  .fs_act      (fs_act),
  .slot_start  (slot_start),
  .slot_tx     (slot_tx),
  .cfg_fs_word (cfg_fs_word),
  .active_pins (active_pins),
  .sdata_o     (sdata_o),
  .last_slot_o (last_slot_o),
  .underrun_o  (underrun_o)
);

// File: tb/sim_tdm_tx_framer.sv
module sim_tdm_tx_framer;

  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic bclk_en = 1'b0;
  logic [5:0] c_slots = 6'd2, c_sw = 6'd16, c_wd = 6'd16;
  logic [7:0] c_ch = 8'd2;
  logic c_net = 1'b1, c_word = 1'b1, c_early = 1'b0, c_inv = 1'b0, c_right = 1'b0;
  logic [15:0] c_mlo = 16'hFFFF, c_mhi = 16'hFFFF;
  logic valid = 1'b1;
  logic [NP*32-1:0] fifo_data;
  logic fifo_pop, fs_o, last_slot_o, underrun_o;
  logic [NP-1:0] sdata_o;

  int word_n = 0;
  int tests = 0;
  int fails = 0;
  int mm_fs, mm_sd, mm_ls, mm_ur, exp_pops, got_pops;

  always #5 clk = ~clk;

  tdm_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk_en(bclk_en),
    .cfg_slots(c_slots), .cfg_slot_w(c_sw), .cfg_width(c_wd), .cfg_chans(c_ch),
    .cfg_network(c_net), .cfg_fs_word(c_word), .cfg_fs_early(c_early),
    .cfg_fs_inv(c_inv), .cfg_right_just(c_right),
    .cfg_mask_lo(c_mlo), .cfg_mask_hi(c_mhi),
    .fifo_valid(valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .fs_o(fs_o), .sdata_o(sdata_o), .last_slot_o(last_slot_o), .underrun_o(underrun_o)
  );

  function automatic logic [31:0] pat(input int n, input int p);
    return {8'(n + 60), 8'(p * 41 + 87), 8'(n ^ 150), 8'(177 + p * 7 + n)};
  endfunction

  always_comb begin
    for (int p = 0; p < NP; p++) fifo_data[p*32 +: 32] = pat(word_n, p);
  end

  always @(posedge clk) if (fifo_pop) word_n <= word_n + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setcfg(input int slots, input int sw, input int wd, input int ch,
                        input bit net, input bit word, input bit early, input bit inv,
                        input bit right, input logic [15:0] mlo, input logic [15:0] mhi);
    c_slots = 6'(slots); c_sw = 6'(sw); c_wd = 6'(wd); c_ch = 8'(ch);
    c_net = net; c_word = word; c_early = early; c_inv = inv; c_right = right;
    c_mlo = mlo; c_mhi = mhi;
  endtask

  function automatic bit slot_on(input int s);
    logic [31:0] m;
    m = {c_mhi, c_mlo};
    return c_net ? m[s] : (s == 0 && m[0]);
  endfunction

  function automatic bit fs_rule(input int s, input int b);
    return (s == 0) && (c_word || b == 0);
  endfunction

  // Bit b (0 = first sent) of a slot holding sample w.
  function automatic bit slot_bit(input logic [31:0] w, input int b);
    int sw, wd;
    sw = int'(c_sw); wd = int'(c_wd);
    if (c_right) return (b >= sw - wd) ? w[sw - 1 - b] : 1'b0;
    return (b < wd) ? w[wd - 1 - b] : 1'b0;
  endfunction

  // Runs nper bit periods from enable and compares every period against the model.
  task automatic run_stream(input int nper);
    int base, ns, sw, fl, txpf, npins;
    base = word_n;
    ns = int'(c_slots); sw = int'(c_sw); fl = ns * sw;
    txpf = 0;
    for (int s = 0; s < ns; s++) if (slot_on(s)) txpf++;
    npins = (int'(c_ch) + ns - 1) / ns;
    if (npins > NP) npins = NP;
    mm_fs = 0; mm_sd = 0; mm_ls = 0; mm_ur = 0; exp_pops = 0;
    @(negedge clk) tx_en = 1'b1;
    for (int k = 0; k < nper; k++) begin
      bit efs, els, eur, tx;
      logic [NP-1:0] esd;
      int idx, f, r, s, b, n, pre, s2, b2;
      @(negedge clk) bclk_en = 1'b1;
      @(negedge clk) bclk_en = 1'b0;
      @(negedge clk);
      esd = '0; els = 0; eur = 0;
      if (k == 0) begin
        efs = c_early ? fs_rule(0, 0) : 1'b0;
      end else begin
        idx = k - 1; f = idx / fl; r = idx % fl; s = r / sw; b = r % sw;
        s2 = ((idx + 1) % fl) / sw; b2 = ((idx + 1) % fl) % sw;
        efs = c_early ? fs_rule(s2, b2) : fs_rule(s, b);
        tx = slot_on(s);
        pre = 0;
        for (int q = 0; q < s; q++) if (slot_on(q)) pre++;
        n = base + f * txpf + pre;
        if (tx && valid)
          for (int p = 0; p < npins; p++) esd[p] = slot_bit(pat(n, p), b);
        els = (b == 0) && (s == ns - 1);
        eur = (b == 0) && tx && !valid;
        if (b == 0 && tx && valid) exp_pops++;
      end
      if (fs_o !== (efs ^ c_inv)) mm_fs++;
      if (sdata_o !== esd) mm_sd++;
      if (last_slot_o !== els) mm_ls++;
      if (underrun_o !== eur) mm_ur++;
    end
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    got_pops = word_n - base;
  endtask

  task automatic t_reset;
    check(fs_o === 1'b0, "R1 fs after reset", int'(fs_o), 0);
    check(sdata_o === '0, "R1 data after reset", int'(sdata_o), 0);
    check(last_slot_o === 1'b0 && underrun_o === 1'b0, "R1 flags after reset",
          int'({last_slot_o, underrun_o}), 0);
    check(fifo_pop === 1'b0, "R1 no pop in reset", int'(fifo_pop), 0);
  endtask

  task automatic t_i2s;
    setcfg(2, 16, 16, 2, 1, 1, 1, 1, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 32 + 3);
    check(mm_fs == 0, "R3 R4 R5 word sync early active-low", mm_fs, 0);
    check(mm_sd == 0, "R2 msb-first stream", mm_sd, 0);
    check(mm_ls == 0, "R11 last slot pulse", mm_ls, 0);
    check(got_pops == exp_pops, "R12 pops per slot", got_pops, exp_pops);
  endtask

  task automatic t_dsp_a;
    setcfg(4, 8, 8, 4, 1, 0, 1, 0, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 32 + 2);
    check(mm_fs == 0, "R4 one-bit sync early", mm_fs, 0);
    check(mm_sd == 0, "R2 four-slot stream", mm_sd, 0);
  endtask

  task automatic t_dsp_b;
    setcfg(3, 6, 6, 3, 1, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 18 + 2);
    check(mm_fs == 0, "R3 one-bit sync on first bit", mm_fs, 0);
    check(mm_ls == 0, "R11 last slot of three", mm_ls, 0);
  endtask

  task automatic t_align;
    setcfg(2, 12, 8, 2, 1, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 24);
    check(mm_sd == 0 && mm_fs == 0, "R6 left aligned pad", mm_sd + mm_fs, 0);
    setcfg(2, 12, 8, 2, 1, 1, 0, 0, 1, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 24);
    check(mm_sd == 0, "R6 right aligned pad", mm_sd, 0);
  endtask

  task automatic t_mask;
    setcfg(4, 4, 4, 4, 1, 1, 0, 0, 0, 16'hFFF5, 16'hFFFF);
    run_stream(1 + 3 * 16);
    check(mm_sd == 0, "R7 masked slots silent", mm_sd, 0);
    check(got_pops == exp_pops && exp_pops == 6, "R7 R12 masked pops", got_pops, exp_pops);
    setcfg(18, 4, 4, 18, 1, 1, 0, 0, 0, 16'hFFFF, 16'hFFFE);
    run_stream(1 + 72 + 8);
    check(mm_sd == 0 && got_pops == exp_pops, "R7 upper half mask", mm_sd, 0);
  endtask

  task automatic t_normal;
    setcfg(4, 8, 8, 1, 0, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 3 * 32);
    check(mm_sd == 0, "R8 normal mode one word", mm_sd, 0);
    check(got_pops == 3 && exp_pops == 3, "R8 one pop per frame", got_pops, 3);
  endtask

  task automatic t_pins;
    setcfg(2, 8, 8, 6, 1, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 16);
    check(mm_sd == 0, "R9 three active pins", mm_sd, 0);
    setcfg(2, 8, 8, 15, 1, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 16);
    check(mm_sd == 0, "R9 pin count capped", mm_sd, 0);
  endtask

  task automatic t_underrun;
    valid = 1'b0;
    setcfg(2, 8, 8, 2, 1, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    run_stream(1 + 2 * 16);
    check(mm_sd == 0, "R10 zeros on underrun", mm_sd, 0);
    check(mm_ur == 0, "R10 underrun pulse", mm_ur, 0);
    check(got_pops == 0, "R10 no pop when empty", got_pops, 0);
    valid = 1'b1;
  endtask

  task automatic t_disable;
    setcfg(2, 16, 16, 2, 1, 1, 1, 1, 0, 16'hFFFF, 16'hFFFF);
    run_stream(9);
    repeat (3) @(negedge clk);
    check(fs_o === 1'b1, "R1 idle sync inactive-low", int'(fs_o), 1);
    check(sdata_o === '0 && last_slot_o === 1'b0, "R1 idle data", int'(sdata_o), 0);
    @(negedge clk) bclk_en = 1'b1;
    @(negedge clk) bclk_en = 1'b0;
    check(fifo_pop === 1'b0 && sdata_o === '0, "R1 tick ignored while disabled",
          int'(sdata_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_i2s();
    t_dsp_a();
    t_dsp_b();
    t_align();
    t_mask();
    t_normal();
    t_pins();
    t_underrun();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(10 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule